// File: doc/BRIEF.md
# Strobe-Ordered DRAM Cycle Decoder

This block sits on the device side of an asynchronous DRAM strobe interface. Three active-low strobes come in from outside: row strobe, column strobe and write strobe. They are synchronised to a fast internal clock. The block then decides what kind of memory cycle the host is running, based only on the order in which the strobes fall. From that decision it latches the row and column from the shared address pins and picks the moment the input data is captured. It also decides when the data output is driven, and it raises a refresh request that carries a row from an internal refresh counter.

The cycles it recognises are these:

- ordinary read;
- early write;
- read-modify-write;
- fast-page accesses inside one open row;
- row-only refresh;
- column-first refresh, where the column strobe is already low when the row strobe falls;
- hidden refresh;
- a compressed test mode, which is entered by a column-first refresh with the write strobe low.

In test mode every write reaches a group of eight cells, and every read reports whether those eight cells agree. Storage is a small parameterised behavioural array. The data output is a value plus a separate drive-enable, so a pad ring can build the tri-state buffer.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, dq_oe and test_mode are 0 and no refresh request is pending. The first refresh request after reset carries row 0.
- R2: Column strobe low when the row strobe falls starts a column-first refresh. It gives one rfsh_req pulse whose rfsh_row is the internal counter, the address pins are ignored, and dq_oe stays 0. The counter steps by one per such refresh and wraps from RFSH_ROWS-1 to 0.
- R3: A row strobe low period with no column strobe (row-only refresh) drives no output, raises no refresh request and changes no cell.
- R4: A read is a column strobe falling while the write strobe is high. It drives dq_out with the addressed cell and sets dq_oe only after the column strobe has fallen. dq_oe returns to 0 after the column strobe rises.
- R5: Write strobe low before the column strobe falls is an early write. din is captured at the column strobe and stored, and dq_oe stays 0 for the whole cycle.
- R6: Write strobe falling after a read has put data on dq_out is a read-modify-write. dq_out keeps the old value until the column strobe rises, and din is written into the same cell.
- R7: While the row strobe stays low, each new column strobe pulse reaches a new column of the same row, and reads and writes may be mixed.
- R8: Holding the column strobe low from a read across a row strobe high-then-low gap is a hidden refresh. dq_oe and dq_out keep the read data while a refresh request is issued.
- R9: A column-first refresh with the write strobe low sets test_mode. A column-first refresh with the write strobe high, or a row-only refresh, clears it.
- R10: In test mode the group is the eight cells that differ only in row bit ROW_W-1, column bit COL_W-1 and column bit 0. A write stores din in all eight cells. A read drives 1 when all eight are equal and 0 when they differ.
- R11: When the row and column strobes fall in the same sample, the row strobe is taken as first. The result is an ordinary access with row and column both taken from the address pins, not a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low, asynchronous |
| col_stb_n | input | 1 | Column strobe, active low, asynchronous |
| wr_stb_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | PIN_W | Multiplexed row/column address pins |
| din | input | 1 | Write data bit |
| dq_out | output | 1 | Read data bit |
| dq_oe | output | 1 | Drive enable for the data output |
| test_mode | output | 1 | Compressed test mode active |
| rfsh_req | output | 1 | One-clock refresh request |
| rfsh_row | output | ROW_W | Row carried with the refresh request |

## Verification
The hardest situations to reach are the ones where two strobe orders meet. One is a hidden refresh: the column strobe stays low from a read while the row strobe goes high and low again. The bench holds the column strobe and toggles only the row strobe, then checks the output for the read value and the refresh counter for one extra pulse. The other is a tie between the row and column strobes. The bench changes both in the same time step so that they land in the same synchronised sample. Test mode is reached by a refresh with the write strobe low. The bench then reads back the grouped cells individually after leaving test mode, and it plants one differing cell before re-entering so that the compare can report a mismatch.

// File: rtl/scd_pkg.sv
package scd_pkg;

  // Access sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,      // row strobe high
    ST_ROW_OPEN,  // row latched, waiting for column strobe
    ST_COL_READ,  // column read, output driven
    ST_COL_WRITE, // column write done, waiting for column strobe high
    ST_AUTO_RFSH  // refresh from the internal counter in progress
  } acc_state_e;

  // Bit positions of the strobes in the synchroniser vector
  localparam int STB_ROW = 0;
  localparam int STB_COL = 1;
  localparam int STB_WR  = 2;
  localparam int STB_NUM = 3;

endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_nxt;

      always_comb begin
        chain_nxt = {chain_q[STAGES-2:0], async_i[gi]};
      end

      // strobes are idle high, so the chain resets high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= chain_nxt;
        end
      end

      assign lvl_o[gi] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scd_refresh_ctr.sv
module scd_refresh_ctr #(
  parameter int ROW_W     = 4,
  parameter int RFSH_ROWS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row_o
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(RFSH_ROWS - 1);

  logic [ROW_W-1:0] cnt_q;
  logic [ROW_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (step) begin
      if (cnt_q == LAST_ROW) begin
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign row_o = cnt_q;

endmodule

// File: rtl/scd_cell_array.sv
module scd_cell_array #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             grp_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic             wr_bit,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic             rd_bit,
  output logic             grp_same
);

  localparam int CW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << CW;
  // address bits that are don't-care inside a test group
  localparam logic [CW-1:0] GRP_MASK =
    CW'((1 << (CW - 1)) | (1 << (COL_W - 1)) | 1);

  logic [DEPTH-1:0] cells;
  logic [DEPTH-1:0] hit;
  logic [CW-1:0]    wr_addr;
  logic [CW-1:0]    rd_addr;
  logic [7:0]       grp_bits;

  assign wr_addr = {wr_row, wr_col};
  assign rd_addr = {rd_row, rd_col};

  genvar gc;
  generate
    for (gc = 0; gc < DEPTH; gc++) begin : g_hit
      assign hit[gc] = grp_en ?
        ((CW'(gc) & ~GRP_MASK) == (wr_addr & ~GRP_MASK)) :
        (CW'(gc) == wr_addr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && hit[i]) begin
        cells[i] <= wr_bit;
      end
    end
  end

  assign rd_bit = cells[rd_addr];

  genvar gk;
  generate
    for (gk = 0; gk < 8; gk++) begin : g_grp
      logic [CW-1:0] var_addr;
      always_comb begin
        var_addr = rd_addr & ~GRP_MASK;
        var_addr[0]       = gk[0];
        var_addr[COL_W-1] = gk[1];
        var_addr[CW-1]    = gk[2];
      end
      assign grp_bits[gk] = cells[var_addr];
    end
  endgenerate

  assign grp_same = (&grp_bits) | ~(|grp_bits);

endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
  import scd_pkg::*;
#(
  parameter int ROW_W       = 4,
  parameter int COL_W       = 4,
  parameter int RFSH_ROWS   = 1 << ROW_W,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb_n,
  input  logic             col_stb_n,
  input  logic             wr_stb_n,
  input  logic [PIN_W-1:0] addr,
  input  logic             din,
  output logic             dq_out,
  output logic             dq_oe,
  output logic             test_mode,
  output logic             rfsh_req,
  output logic [ROW_W-1:0] rfsh_row
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_l = rst_pipe_q[1];

  // strobe synchronisers
  logic [STB_NUM-1:0] stb_async;
  logic [STB_NUM-1:0] stb_lvl;

  assign stb_async[STB_ROW] = row_stb_n;
  assign stb_async[STB_COL] = col_stb_n;
  assign stb_async[STB_WR]  = wr_stb_n;

  scd_sync #(.N(STB_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_l),
    .async_i (stb_async),
    .lvl_o   (stb_lvl)
  );

  logic row_hi, col_hi, wr_hi;
  logic col_prev_q;
  logic col_fall, col_rise;

  assign row_hi   = stb_lvl[STB_ROW];
  assign col_hi   = stb_lvl[STB_COL];
  assign wr_hi    = stb_lvl[STB_WR];
  assign col_fall = col_prev_q & ~col_hi;
  assign col_rise = ~col_prev_q & col_hi;

  // refresh counter
  logic             ctr_step;
  logic [ROW_W-1:0] ctr_row;

  scd_refresh_ctr #(.ROW_W(ROW_W), .RFSH_ROWS(RFSH_ROWS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_l),
    .step  (ctr_step),
    .row_o (ctr_row)
  );

  // sequencer state
  acc_state_e       state_q,   state_nxt;
  logic [ROW_W-1:0] row_q,     row_nxt;
  logic [COL_W-1:0] col_q,     col_nxt;
  logic             seen_q,    seen_nxt;
  logic             tmode_q,   tmode_nxt;
  logic             dout_q,    dout_nxt;
  logic             oe_q,      oe_nxt;
  logic             req_q,     req_nxt;
  logic [ROW_W-1:0] rrow_q,    rrow_nxt;

  // array interface
  logic             arr_wr;
  logic [COL_W-1:0] arr_wcol;
  logic             arr_rbit;
  logic             arr_same;
  logic [COL_W-1:0] pin_col;
  logic [ROW_W-1:0] pin_row;

  assign pin_col = addr[COL_W-1:0];
  assign pin_row = addr[ROW_W-1:0];

  always_comb begin
    state_nxt = state_q;
    row_nxt   = row_q;
    col_nxt   = col_q;
    seen_nxt  = seen_q;
    tmode_nxt = tmode_q;
    dout_nxt  = dout_q;
    oe_nxt    = oe_q;
    req_nxt   = 1'b0;
    rrow_nxt  = rrow_q;
    ctr_step  = 1'b0;
    arr_wr    = 1'b0;
    arr_wcol  = col_q;

    // output is released whenever the column strobe returns high
    if (col_rise) begin
      oe_nxt = 1'b0;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (!row_hi) begin
          if (!col_hi && !col_fall) begin
            // column strobe was already low: refresh from the counter
            state_nxt = ST_AUTO_RFSH;
            req_nxt   = 1'b1;
            rrow_nxt  = ctr_row;
            ctr_step  = 1'b1;
            tmode_nxt = ~wr_hi;
          end else begin
            // ordinary row open (a tie counts as row first)
            state_nxt = ST_ROW_OPEN;
            row_nxt   = pin_row;
            seen_nxt  = 1'b0;
          end
        end
      end

      ST_ROW_OPEN: begin
        if (row_hi) begin
          state_nxt = ST_IDLE;
          if (!seen_q) begin
            tmode_nxt = 1'b0;   // row-only refresh ends test mode
          end
        end else if (!col_hi) begin
          col_nxt  = pin_col;
          seen_nxt = 1'b1;
          if (!wr_hi) begin
            arr_wr    = 1'b1;
            arr_wcol  = pin_col;
            state_nxt = ST_COL_WRITE;
          end else begin
            dout_nxt  = tmode_q ? arr_same : arr_rbit;
            oe_nxt    = 1'b1;
            state_nxt = ST_COL_READ;
          end
        end
      end

      ST_COL_READ: begin
        if (row_hi) begin
          state_nxt = ST_IDLE;
        end else if (col_hi) begin
          state_nxt = ST_ROW_OPEN;
        end else if (!wr_hi) begin
          arr_wr    = 1'b1;   // late write strobe: modify the read cell
          arr_wcol  = col_q;
          state_nxt = ST_COL_WRITE;
        end
      end

      ST_COL_WRITE: begin
        if (row_hi) begin
          state_nxt = ST_IDLE;
        end else if (col_hi) begin
          state_nxt = ST_ROW_OPEN;
        end
      end

      ST_AUTO_RFSH: begin
        if (row_hi) begin
          state_nxt = ST_IDLE;
        end
      end

      default: begin
        state_nxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      seen_q     <= 1'b0;
      tmode_q    <= 1'b0;
      dout_q     <= 1'b0;
      oe_q       <= 1'b0;
      req_q      <= 1'b0;
      rrow_q     <= '0;
      col_prev_q <= 1'b1;
    end else begin
      state_q    <= state_nxt;
      row_q      <= row_nxt;
      col_q      <= col_nxt;
      seen_q     <= seen_nxt;
      tmode_q    <= tmode_nxt;
      dout_q     <= dout_nxt;
      oe_q       <= oe_nxt;
      req_q      <= req_nxt;
      rrow_q     <= rrow_nxt;
      col_prev_q <= col_hi;
    end
  end

  scd_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk      (clk),
    .wr_en    (arr_wr),
    .grp_en   (tmode_q),
    .wr_row   (row_q),
    .wr_col   (arr_wcol),
    .wr_bit   (din),
    .rd_row   (row_q),
    .rd_col   (pin_col),
    .rd_bit   (arr_rbit),
    .grp_same (arr_same)
  );

  assign dq_out    = dout_q;
  assign dq_oe     = oe_q;
  assign test_mode = tmode_q;
  assign rfsh_req  = req_q;
  assign rfsh_row  = rrow_q;

endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int ROW_W     = 4,
  parameter int RFSH_ROWS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_stb_n,
  input logic             col_stb_n,
  input logic             wr_stb_n,
  input logic             dq_out,
  input logic             dq_oe,
  input logic             test_mode,
  input logic             rfsh_req,
  input logic [ROW_W-1:0] rfsh_row
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(RFSH_ROWS - 1);

  logic             seen_q;
  logic [ROW_W-1:0] last_q;
  logic [ROW_W-1:0] want_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (rfsh_req) begin
      seen_q <= 1'b1;
      last_q <= rfsh_row;
    end
  end

  assign want_row = (last_q == LAST_ROW) ? '0 : last_q + 1'b1;

  // R1
  first_rfsh_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !seen_q) |-> (rfsh_row == '0));

  // R2
  rfsh_row_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && seen_q) |-> (rfsh_row == want_row));

  // R2
  rfsh_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |=> !rfsh_req);

  // R2
  rfsh_strobes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> (!row_stb_n && !col_stb_n));

  // R4
  drive_after_col_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> !col_stb_n);

  // R4
  release_after_col_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> col_stb_n);

  // R5
  no_drive_on_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> wr_stb_n);

  // R6
  held_output_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

  // R9
  test_entry_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> (!wr_stb_n && !col_stb_n && !row_stb_n));

endmodule

bind strobe_cycle_decoder scd_checker #(.ROW_W(ROW_W), .RFSH_ROWS(RFSH_ROWS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .row_stb_n (row_stb_n),
  .col_stb_n (col_stb_n),
  .wr_stb_n  (wr_stb_n),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .test_mode (test_mode),
  .rfsh_req  (rfsh_req),
  .rfsh_row  (rfsh_row)
);

// File: tb/strobe_cycle_decoder_bench.sv
module strobe_cycle_decoder_bench;

  localparam int ROW_W     = 4;
  localparam int COL_W     = 4;
  localparam int RFSH_ROWS = 16;
  localparam int PIN_W     = 4;
  localparam int NR        = 1 << ROW_W;
  localparam int NC        = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             row_stb_n, col_stb_n, wr_stb_n, din;
  logic [PIN_W-1:0] addr;
  logic             dq_out, dq_oe, test_mode, rfsh_req;
  logic [ROW_W-1:0] rfsh_row;

  always #5 clk = ~clk;

  strobe_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .RFSH_ROWS(RFSH_ROWS)) u_strobe_cycle_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_stb_n (row_stb_n),
    .col_stb_n (col_stb_n),
    .wr_stb_n  (wr_stb_n),
    .addr      (addr),
    .din       (din),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .test_mode (test_mode),
    .rfsh_req  (rfsh_req),
    .rfsh_row  (rfsh_row)
  );

  // channels compared by the monitor
  localparam int CH_DOUT = 0;
  localparam int CH_OE   = 1;
  localparam int CH_TM   = 2;
  localparam int CH_RCNT = 3;
  localparam int CH_RROW = 4;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  int    q_chan[$];
  int    q_exp[$];
  string q_tag[$];
  event  smp_ev;

  int rf_cnt = 0;
  int rf_last = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rfsh_req === 1'b1) begin
      rf_cnt  = rf_cnt + 1;
      rf_last = int'(rfsh_row);
    end
  end

  bit mdl [0:NR-1][0:NC-1];
  int exp_cnt = 0;
  int exp_row = 0;
  bit tm = 1'b0;
  int cur_row = 0;

  function automatic int actual(int ch);
    case (ch)
      CH_DOUT: return int'(dq_out);
      CH_OE:   return int'(dq_oe);
      CH_TM:   return int'(test_mode);
      CH_RCNT: return rf_cnt;
      default: return rf_last;
    endcase
  endfunction

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(smp_ev);
      while (q_chan.size() > 0) begin
        int    ch;
        int    ex;
        int    ac;
        string tg;
        ch = q_chan.pop_front();
        ex = q_exp.pop_front();
        tg = q_tag.pop_front();
        ac = actual(ch);
        n_chk++;
        if (ac != ex) begin
          n_fail++;
          $display("FAIL %s: channel %0d actual %0d expected %0d", tg, ch, ac, ex);
        end
      end
    end
  end

  task automatic expect_v(input int ch, input int ex, input string tg);
    q_chan.push_back(ch);
    q_exp.push_back(ex);
    q_tag.push_back(tg);
  endtask

  task automatic probe();
    -> smp_ev;
    #1;
  endtask

  task automatic wt();
    repeat (8) @(negedge clk);
  endtask

  function automatic int grp_row(input int r, input int k);
    return (r & ~(1 << (ROW_W - 1))) | (((k >> 2) & 1) << (ROW_W - 1));
  endfunction

  function automatic int grp_col(input int c, input int k);
    return (c & ~((1 << (COL_W - 1)) | 1)) | (((k >> 1) & 1) << (COL_W - 1)) | (k & 1);
  endfunction

  function automatic int grp_eq(input int r, input int c);
    int ones;
    ones = 0;
    for (int k = 0; k < 8; k++) begin
      ones += int'(mdl[grp_row(r, k)][grp_col(c, k)]);
    end
    return ((ones == 0) || (ones == 8)) ? 1 : 0;
  endfunction

  task automatic model_write(input int c, input bit b);
    if (tm) begin
      for (int k = 0; k < 8; k++) begin
        mdl[grp_row(cur_row, k)][grp_col(c, k)] = b;
      end
    end else begin
      mdl[cur_row][c] = b;
    end
  endtask

  task automatic ras_open(input int r);
    addr = PIN_W'(r);
    wt();
    row_stb_n = 1'b0;
    cur_row   = r;
    wt();
  endtask

  task automatic ras_close();
    row_stb_n = 1'b1;
    wt();
  endtask

  task automatic col_write(input int c, input bit b);
    addr     = PIN_W'(c);
    din      = b;
    wr_stb_n = 1'b0;
    wt();
    col_stb_n = 1'b0;
    wt();
    expect_v(CH_OE, 0, "R5 early write keeps output off");
    probe();
    col_stb_n = 1'b1;
    wr_stb_n  = 1'b1;
    wt();
    model_write(c, b);
  endtask

  task automatic col_read(input int c, input string tg);
    int ex;
    addr = PIN_W'(c);
    wt();
    col_stb_n = 1'b0;
    wt();
    ex = tm ? grp_eq(cur_row, c) : int'(mdl[cur_row][c]);
    expect_v(CH_OE, 1, tg);
    expect_v(CH_DOUT, ex, tg);
    probe();
    col_stb_n = 1'b1;
    wt();
    expect_v(CH_OE, 0, "R4 output released after column strobe rise");
    probe();
  endtask

  task automatic col_rmw(input int c, input bit b);
    int old;
    addr = PIN_W'(c);
    wt();
    col_stb_n = 1'b0;
    wt();
    old = int'(mdl[cur_row][c]);
    expect_v(CH_OE, 1, "R6 read phase drives");
    expect_v(CH_DOUT, old, "R6 read phase data");
    probe();
    din      = b;
    wr_stb_n = 1'b0;
    wt();
    expect_v(CH_OE, 1, "R6 output held during modify");
    expect_v(CH_DOUT, old, "R6 old data kept during modify");
    probe();
    col_stb_n = 1'b1;
    wr_stb_n  = 1'b1;
    wt();
    model_write(c, b);
  endtask

  task automatic cbr(input bit we_lvl, input string tg);
    col_stb_n = 1'b0;
    wr_stb_n  = we_lvl;
    wt();
    addr      = PIN_W'(4'hA);
    row_stb_n = 1'b0;
    wt();
    exp_cnt++;
    expect_v(CH_RCNT, exp_cnt, tg);
    expect_v(CH_RROW, exp_row, tg);
    expect_v(CH_OE, 0, tg);
    exp_row = (exp_row + 1) % RFSH_ROWS;
    tm      = ~we_lvl;
    expect_v(CH_TM, int'(tm), "R9 test mode after column-first refresh");
    probe();
    row_stb_n = 1'b1;
    wt();
    col_stb_n = 1'b1;
    wr_stb_n  = 1'b1;
    wt();
  endtask

  task automatic ras_only(input int r);
    ras_open(r);
    expect_v(CH_OE, 0, "R3 row-only refresh output off");
    expect_v(CH_RCNT, exp_cnt, "R3 row-only refresh no request");
    probe();
    ras_close();
    tm = 1'b0;
    expect_v(CH_TM, 0, "R9 row-only refresh leaves test mode");
    probe();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n     = 1'b0;
    row_stb_n = 1'b1;
    col_stb_n = 1'b1;
    wr_stb_n  = 1'b1;
    din       = 1'b0;
    addr      = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wt();

    // R1 reset state
    expect_v(CH_OE, 0, "R1 reset output enable");
    expect_v(CH_TM, 0, "R1 reset test mode");
    expect_v(CH_RCNT, 0, "R1 no refresh after reset");
    probe();

    // R7 fast page: writes and reads in one open row
    ras_open(1);
    col_write(2, 1'b1);
    col_write(5, 1'b0);
    col_write(9, 1'b1);
    col_read(2, "R7 page read col 2");
    col_read(5, "R7 page read col 5");
    col_read(9, "R7 page read col 9");
    ras_close();

    // R5 single early write, R4 read in a fresh cycle
    ras_open(3);
    col_write(3, 1'b1);
    ras_close();
    ras_open(3);
    col_read(3, "R4 read after write");
    ras_close();

    // R6 read-modify-write then read back
    ras_open(3);
    col_rmw(3, 1'b0);
    col_read(3, "R6 modified value stored");
    ras_close();

    // R3 row-only refresh leaves data alone
    ras_only(3);
    ras_open(3);
    col_read(3, "R3 cell unchanged by row-only refresh");
    ras_close();

    // R2 counter refresh with wrap after RFSH_ROWS requests
    for (int i = 0; i < RFSH_ROWS + 1; i++) begin
      cbr(1'b1, "R2 refresh row from counter");
    end

    // R8 hidden refresh
    ras_open(6);
    col_write(7, 1'b1);
    addr = PIN_W'(7);
    wt();
    col_stb_n = 1'b0;
    wt();
    expect_v(CH_OE, 1, "R8 read before hidden refresh");
    expect_v(CH_DOUT, 1, "R8 read before hidden refresh");
    probe();
    row_stb_n = 1'b1;
    wt();
    row_stb_n = 1'b0;
    wt();
    exp_cnt++;
    expect_v(CH_OE, 1, "R8 output kept in hidden refresh");
    expect_v(CH_DOUT, 1, "R8 data kept in hidden refresh");
    expect_v(CH_RCNT, exp_cnt, "R8 hidden refresh request");
    expect_v(CH_RROW, exp_row, "R8 hidden refresh row");
    exp_row = (exp_row + 1) % RFSH_ROWS;
    probe();
    row_stb_n = 1'b1;
    wt();
    col_stb_n = 1'b1;
    wt();
    expect_v(CH_OE, 0, "R8 release after hidden refresh");
    probe();

    // R11 simultaneous row and column strobe fall
    ras_open(5);
    col_write(5, 1'b1);
    ras_close();
    addr = PIN_W'(5);
    wt();
    row_stb_n = 1'b0;
    col_stb_n = 1'b0;
    wt();
    expect_v(CH_OE, 1, "R11 tie gives ordinary read");
    expect_v(CH_DOUT, 1, "R11 tie read data");
    expect_v(CH_RCNT, exp_cnt, "R11 tie raises no refresh");
    probe();
    col_stb_n = 1'b1;
    row_stb_n = 1'b1;
    wt();

    // R9 and R10 test mode
    cbr(1'b0, "R9 enter test mode");
    ras_open(2);
    col_write(6, 1'b1);
    col_read(6, "R10 group equal reads high");
    ras_close();
    ras_only(0);
    ras_open(2 | (1 << (ROW_W - 1)));
    col_read(6 | (1 << (COL_W - 1)) | 1, "R10 group write reached far cell");
    col_write(6 | (1 << (COL_W - 1)) | 1, 1'b0);
    ras_close();
    ras_open(2);
    col_read(7, "R10 group write reached neighbour cell");
    ras_close();
    cbr(1'b0, "R9 re-enter test mode");
    ras_open(2);
    col_read(6, "R10 group differing reads low");
    ras_close();
    cbr(1'b1, "R9 leave test mode by refresh");

    done = 1'b1;
    finish_run();
  end

endmodule